// File: doc/BRIEF.md
# Reduced-Matrix Slice Reconstructor

This block sits at the end of a sub-Nyquist receive chain. It accepts vectors of twelve complex channel samples, one vector per cycle, and keeps them in a local buffer. A controller loads a reduced inverse matrix into the block, one complex coefficient per write. The matrix has one row for each frequency slice found to carry energy and one column for each channel. When the controller raises a start pulse, the block multiplies every buffered vector by the loaded rows. The result is only the active slices, streamed out one complex sample per cycle toward a DMA-style sink.

A run is fixed by the number of buffered vectors and by the active-slice count sampled at the start pulse. For each vector the block emits one beat per active slice, and it flags the final beat of the run. While a run is in progress, new input vectors are dropped. Matrix writes are refused and reported, so the run in progress always sees a consistent matrix. When the run ends, the buffer is emptied and the block is ready to capture again.

Top module: `slice_recon`

## Requirements
- R1: While idle, each cycle with `in_valid` high and fewer than DEPTH (1024) vectors stored appends the vector to the buffer in arrival order. `full` is high exactly when DEPTH vectors are stored.
- R2: An `in_valid` cycle while idle with the buffer full stores nothing and sets `ovf`. `ovf` stays high until the next accepted start, which clears it.
- R3: A `start` pulse while idle with at least one vector stored is accepted, and `busy` is high from the next cycle. A `start` while busy or with an empty buffer does nothing. An `in_valid` in the same cycle as an accepted start is dropped.
- R4: The slice count K is taken from `k_active` at the accepted start and held for the run. A value of 0 runs as 1, and values above 12 run as 12.
- R5: Each output beat for vector x and slice s carries the exact signed sums out_re = Σc (Cre[s][c]·xre[c] − Cim[s][c]·xim[c]) and out_im = Σc (Cre[s][c]·xim[c] + Cim[s][c]·xre[c]), with no rounding, in 38 bits. Channel c occupies bits [16c+15:16c] of `in_re` and `in_im`.
- R6: A run emits exactly N·K beats, one per cycle: vectors in stored order, and slices 0..K−1 within each vector, with `out_slice` giving s. The first beat appears two cycles after `busy` rises.
- R7: `out_last` is high on the final beat of a run and on no other cycle.
- R8: A load (`ld_valid`) while idle writes the signed coefficient (`ld_re`, `ld_im`) to row `ld_row`, column `ld_col`. A load with row or column of 12 or more changes nothing. All coefficients are zero after reset.
- R9: A load while busy leaves the matrix unchanged, and `ld_err` is high for one cycle in the next cycle. `ld_err` is low otherwise.
- R10: `busy` falls in the cycle after the last beat's address is issued, and the buffer is empty from then on. A further start with no new capture is ignored.
- R11: `in_valid` cycles while busy store nothing and do not set `ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input vector present this cycle |
| in_re | input | 192 | Real parts of the twelve channels, 16 bits each |
| in_im | input | 192 | Imaginary parts of the twelve channels, 16 bits each |
| ld_valid | input | 1 | Coefficient write strobe |
| ld_row | input | 4 | Coefficient row (slice) |
| ld_col | input | 4 | Coefficient column (channel) |
| ld_re | input | 16 | Coefficient real part, signed |
| ld_im | input | 16 | Coefficient imaginary part, signed |
| k_active | input | 4 | Active slice count for the next run |
| start | input | 1 | Run trigger |
| out_valid | output | 1 | Output beat valid |
| out_re | output | 38 | Reconstructed real part, signed |
| out_im | output | 38 | Reconstructed imaginary part, signed |
| out_slice | output | 4 | Slice index of the beat |
| out_last | output | 1 | Final beat of the run |
| busy | output | 1 | Run in progress |
| full | output | 1 | Buffer holds DEPTH vectors |
| ovf | output | 1 | Input arrived while the buffer was full |
| ld_err | output | 1 | A load was refused during a run |

## Verification
The overflow path is the hardest state to reach from the ports. The buffer must be filled with 1024 distinct vectors, a few more must be pushed against the full buffer, and then every one of the 1024 stored vectors must come out intact in a single K=1 run. The stimulus streams 1027 numbered vectors back to back for this purpose. Coefficient writes and input vectors are also driven during a run, and a follow-up run checks that neither leaked into the matrix or the buffer. A behavioural model predicts every output port on every cycle.

// File: rtl/slice_recon_pkg.sv
// Package: shared defaults and helpers for the slice reconstructor.
// Assumes: nothing; holds constants and pure functions only.
package slice_recon_pkg;
    localparam int NCH_DEF   = 12;   // channels per input vector
    localparam int SW_DEF    = 16;   // sample width (each of re/im)
    localparam int CW_DEF    = 16;   // coefficient width (each of re/im)
    localparam int DEPTH_DEF = 1024; // vectors held in the buffer

    // Clamp a requested slice count into 1..n.
    function automatic int kclamp(input int k, input int n);
        if (k < 1)
            return 1;
        else if (k > n)
            return n;
        else
            return k;
    endfunction
endpackage

// File: rtl/sr_capture.sv
// Module: sample buffer for the slice reconstructor.
// Writes input vectors in arrival order while not held, tracks the fill
// count and an overflow flag, and gives a registered read port.
// Assumes: clr is asserted only while hold is high (during a run).
module sr_capture #(
    parameter int NCH   = 12,
    parameter int SW    = 16,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH),
    localparam int VW   = 2 * NCH * SW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          hold,
    input  logic          clr,
    input  logic          clr_ovf,
    input  logic [VW-1:0] in_vec,
    input  logic [AW-1:0] rd_addr,
    output logic [VW-1:0] rd_data,
    output logic [AW:0]   count,
    output logic          full,
    output logic          ovf
);
    logic [VW-1:0] mem [DEPTH];
    logic          wr_en;

    assign full  = (count == (AW+1)'(DEPTH));
    assign wr_en = in_valid && !hold && !full;

    // Fill counter: advances per stored vector, emptied at run end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (wr_en)
            count <= count + (AW+1)'(1);
    end

    // Overflow flag: sticky until the next accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf <= 1'b0;
        else if (clr_ovf)
            ovf <= 1'b0;
        else if (in_valid && !hold && full)
            ovf <= 1'b1;
    end

    // Storage array with a registered read port.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[count[AW-1:0]] <= in_vec;
        rd_data <= mem[rd_addr];
    end

    // R1
    fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !hold && !full && !clr) |=> (count == $past(count) + (AW+1)'(1)));
    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !hold && full && !clr_ovf) |=> (ovf && count == (AW+1)'(DEPTH)));
    // R11
    hold_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr) |=> $stable(count));
endmodule

// File: rtl/sr_coef_bank.sv
// Module: reduced inverse matrix storage.
// Accepts single-coefficient writes while idle, refuses them while a run
// is active (flagging ld_err next cycle), and registers one row per cycle
// for the multiplier. Row output layout: {imag[NCH], real[NCH]}.
// Assumes: rd_row is below NCH whenever its registered row is consumed.
module sr_coef_bank #(
    parameter int NCH = 12,
    parameter int CW  = 16,
    localparam int IW = $clog2(NCH + 1),
    localparam int RW = 2 * NCH * CW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_valid,
    input  logic [IW-1:0]        ld_row,
    input  logic [IW-1:0]        ld_col,
    input  logic signed [CW-1:0] ld_re,
    input  logic signed [CW-1:0] ld_im,
    input  logic                 busy,
    input  logic [IW-1:0]        rd_row,
    output logic [RW-1:0]        row_q,
    output logic                 ld_err
);
    logic signed [CW-1:0] cre [NCH][NCH];
    logic signed [CW-1:0] cim [NCH][NCH];
    logic                 wr_ok;

    assign wr_ok = ld_valid && !busy && (ld_row < IW'(NCH)) && (ld_col < IW'(NCH));

    // Coefficient array: cleared on reset, written while idle only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NCH; r++) begin
                for (int c = 0; c < NCH; c++) begin
                    cre[r][c] <= '0;
                    cim[r][c] <= '0;
                end
            end
        end else if (wr_ok) begin
            cre[ld_row][ld_col] <= ld_re;
            cim[ld_row][ld_col] <= ld_im;
        end
    end

    // Refusal flag: one-cycle pulse after a load during a run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ld_err <= 1'b0;
        else
            ld_err <= ld_valid && busy;
    end

    // Row register feeding the multiplier stage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            row_q <= '0;
        else if (rd_row < IW'(NCH)) begin
            for (int c = 0; c < NCH; c++) begin
                row_q[c*CW +: CW]         <= cre[rd_row][c];
                row_q[(NCH+c)*CW +: CW]   <= cim[rd_row][c];
            end
        end
    end

    // R9
    refuse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && busy) |=> ld_err);
    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_valid && busy) |=> !ld_err);
endmodule

// File: rtl/sr_sequencer.sv
// Module: run sequencer.
// On an accepted start it latches the clamped slice count and walks
// (vector, slice) addresses one per cycle, slice-minor, until the last
// stored vector's last slice; gen_last marks that final address.
// Assumes: count stays constant while busy (capture is held).
module sr_sequencer #(
    parameter int NCH   = 12,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH),
    localparam int IW   = $clog2(NCH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_acc,
    input  logic [IW-1:0] k_in,
    input  logic [AW:0]   count,
    output logic          busy,
    output logic [AW-1:0] v_idx,
    output logic [IW-1:0] s_idx,
    output logic          gen_last
);
    logic [IW-1:0] k_lat;
    logic          slice_end;
    logic          vec_end;

    assign slice_end = (s_idx == k_lat - IW'(1));
    assign vec_end   = ({1'b0, v_idx} == count - (AW+1)'(1));
    assign gen_last  = busy && slice_end && vec_end;

    // Address walk and run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            v_idx <= '0;
            s_idx <= '0;
            k_lat <= IW'(1);
        end else if (start_acc) begin
            busy  <= 1'b1;
            v_idx <= '0;
            s_idx <= '0;
            k_lat <= IW'(slice_recon_pkg::kclamp(int'(k_in), NCH));
        end else if (busy) begin
            if (slice_end) begin
                s_idx <= '0;
                if (vec_end)
                    busy <= 1'b0;
                else
                    v_idx <= v_idx + AW'(1);
            end else begin
                s_idx <= s_idx + IW'(1);
            end
        end
    end

    // R3
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> (busy && v_idx == '0 && s_idx == '0));
    // R4
    slice_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (s_idx < k_lat && k_lat <= IW'(NCH) && k_lat != '0));
    // R10
    run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_last |=> !busy);
endmodule

// File: rtl/sr_mac.sv
// Module: complex dot-product stage.
// Takes a registered sample vector and a registered coefficient row,
// forms the exact complex inner product over all channels and registers
// it with its slice tag. Vector and row layouts: {imag[NCH], real[NCH]}.
// Assumes: vec and row arrive one cycle after the address tags.
module sr_mac #(
    parameter int NCH = 12,
    parameter int SW  = 16,
    parameter int CW  = 16,
    localparam int IW = $clog2(NCH + 1),
    localparam int PW = SW + CW + 1,
    localparam int OW = SW + CW + $clog2(NCH) + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 gen_valid,
    input  logic [IW-1:0]        gen_slice,
    input  logic                 gen_last,
    input  logic [2*NCH*SW-1:0]  vec,
    input  logic [2*NCH*CW-1:0]  row,
    output logic                 out_valid,
    output logic [IW-1:0]        out_slice,
    output logic                 out_last,
    output logic signed [OW-1:0] out_re,
    output logic signed [OW-1:0] out_im
);
    logic                 t_valid;
    logic [IW-1:0]        t_slice;
    logic                 t_last;
    logic signed [PW-1:0] pr [NCH];
    logic signed [PW-1:0] pi [NCH];
    logic signed [OW-1:0] acc_re;
    logic signed [OW-1:0] acc_im;

    // Per-channel complex products.
    for (genvar c = 0; c < NCH; c++) begin : g_prod
        logic signed [PW-1:0] xr, xi, cr, ci;
        assign xr = PW'($signed(vec[c*SW +: SW]));
        assign xi = PW'($signed(vec[(NCH+c)*SW +: SW]));
        assign cr = PW'($signed(row[c*CW +: CW]));
        assign ci = PW'($signed(row[(NCH+c)*CW +: CW]));
        assign pr[c] = xr * cr - xi * ci;
        assign pi[c] = xi * cr + xr * ci;
    end

    // Channel accumulation at full precision.
    always_comb begin
        acc_re = '0;
        acc_im = '0;
        for (int c = 0; c < NCH; c++) begin
            acc_re = acc_re + OW'(pr[c]);
            acc_im = acc_im + OW'(pi[c]);
        end
    end

    // Tag delay aligning with the registered vector and row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_valid <= 1'b0;
            t_slice <= '0;
            t_last  <= 1'b0;
        end else begin
            t_valid <= gen_valid;
            t_slice <= gen_slice;
            t_last  <= gen_last;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_slice <= '0;
            out_last  <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= t_valid;
            out_slice <= t_slice;
            out_last  <= t_valid && t_last;
            out_re    <= t_valid ? acc_re : '0;
            out_im    <= t_valid ? acc_im : '0;
        end
    end

    // R7
    last_in_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
    // R6
    beat_follows_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_valid |=> out_valid);
endmodule

// File: rtl/slice_recon.sv
// Module: reduced-matrix slice reconstructor (top).
// Buffers twelve-channel complex vectors, and on an accepted start
// multiplies each by the active rows of a loaded reduced inverse matrix,
// streaming one slice sample per cycle with a last-beat marker.
// Assumes: the consumer accepts one beat per cycle without back-pressure.
module slice_recon #(
    parameter int NCH   = slice_recon_pkg::NCH_DEF,
    parameter int SW    = slice_recon_pkg::SW_DEF,
    parameter int CW    = slice_recon_pkg::CW_DEF,
    parameter int DEPTH = slice_recon_pkg::DEPTH_DEF,
    localparam int AW   = $clog2(DEPTH),
    localparam int IW   = $clog2(NCH + 1),
    localparam int OW   = SW + CW + $clog2(NCH) + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [NCH*SW-1:0]    in_re,
    input  logic [NCH*SW-1:0]    in_im,
    input  logic                 ld_valid,
    input  logic [IW-1:0]        ld_row,
    input  logic [IW-1:0]        ld_col,
    input  logic signed [CW-1:0] ld_re,
    input  logic signed [CW-1:0] ld_im,
    input  logic [IW-1:0]        k_active,
    input  logic                 start,
    output logic                 out_valid,
    output logic signed [OW-1:0] out_re,
    output logic signed [OW-1:0] out_im,
    output logic [IW-1:0]        out_slice,
    output logic                 out_last,
    output logic                 busy,
    output logic                 full,
    output logic                 ovf,
    output logic                 ld_err
);
    logic [AW:0]           count;
    logic [AW-1:0]         v_idx;
    logic [IW-1:0]         s_idx;
    logic                  gen_last;
    logic                  start_acc;
    logic [2*NCH*SW-1:0]   rd_data;
    logic [2*NCH*CW-1:0]   row_q;

    assign start_acc = start && !busy && (count != '0);

    sr_capture #(.NCH(NCH), .SW(SW), .DEPTH(DEPTH)) u_cap (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .hold(busy || start_acc), .clr(gen_last), .clr_ovf(start_acc),
        .in_vec({in_im, in_re}), .rd_addr(v_idx), .rd_data(rd_data),
        .count(count), .full(full), .ovf(ovf)
    );

    sr_coef_bank #(.NCH(NCH), .CW(CW)) u_coef (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_row(ld_row),
        .ld_col(ld_col), .ld_re(ld_re), .ld_im(ld_im), .busy(busy),
        .rd_row(s_idx), .row_q(row_q), .ld_err(ld_err)
    );

    sr_sequencer #(.NCH(NCH), .DEPTH(DEPTH)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .k_in(k_active),
        .count(count), .busy(busy), .v_idx(v_idx), .s_idx(s_idx),
        .gen_last(gen_last)
    );

    sr_mac #(.NCH(NCH), .SW(SW), .CW(CW)) u_mac (
        .clk(clk), .rst_n(rst_n), .gen_valid(busy), .gen_slice(s_idx),
        .gen_last(gen_last), .vec(rd_data), .row(row_q),
        .out_valid(out_valid), .out_slice(out_slice), .out_last(out_last),
        .out_re(out_re), .out_im(out_im)
    );

    // R3
    idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(ovf) || !busy);
    // R10
    empty_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_last |=> (count == '0 && !full));
endmodule

// File: tb/sim_slice_recon.sv
// Bench: behavioural reference model (queues, integers) stepped once per
// clock and compared against every output each cycle, plus scenario checks.
module sim_slice_recon;
    localparam int NCH = 12, SW = 16, CW = 16, DEPTH = 1024, IW = 4, OW = 38;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [NCH*SW-1:0] in_re = '0, in_im = '0;
    logic ld_valid = 1'b0;
    logic [IW-1:0] ld_row = '0, ld_col = '0, k_active = '0;
    logic signed [CW-1:0] ld_re = '0, ld_im = '0;
    logic start = 1'b0;
    logic out_valid, out_last, busy, full, ovf, ld_err;
    logic signed [OW-1:0] out_re, out_im;
    logic [IW-1:0] out_slice;

    slice_recon u0 (.*);

    always #4 clk = ~clk; // 125 MHz

    int total = 0, bad = 0, beats = 0;
    longint last_re = 0, last_im = 0;
    bit finished = 0;

    // reference model state
    int q_re[$], q_im[$];
    int c_re[NCH][NCH], c_im[NCH][NCH];
    bit m_busy, m_ovf, m_err;
    int m_v, m_s, m_k;
    bit p1_v, p1_l, o_v, o_l;
    int p1_s, o_s;
    longint p1_re, p1_im, o_re, o_im;

    function automatic int sval(input int a);
        return ((a * 7919 + 12345) % 65536) - 32768;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        int cnt;
        cnt = q_re.size() / NCH;
        if (!rst_n) begin
            q_re.delete(); q_im.delete();
            for (int r = 0; r < NCH; r++)
                for (int c = 0; c < NCH; c++) begin c_re[r][c] = 0; c_im[r][c] = 0; end
            m_busy = 0; m_ovf = 0; m_err = 0; m_v = 0; m_s = 0; m_k = 1;
            p1_v = 0; p1_l = 0; p1_s = 0; p1_re = 0; p1_im = 0;
            o_v = 0; o_l = 0; o_s = 0; o_re = 0; o_im = 0;
            return;
        end
        o_v = p1_v; o_l = p1_l; o_s = p1_s; o_re = p1_re; o_im = p1_im;
        if (m_busy) begin
            p1_v = 1; p1_s = m_s; p1_re = 0; p1_im = 0;
            for (int c = 0; c < NCH; c++) begin
                longint xr, xi, cr, ci;
                xr = q_re[m_v*NCH+c]; xi = q_im[m_v*NCH+c];
                cr = c_re[m_s][c];    ci = c_im[m_s][c];
                p1_re += cr*xr - ci*xi;
                p1_im += cr*xi + ci*xr;
            end
            p1_l = (m_v == cnt-1) && (m_s == m_k-1);
        end else begin
            p1_v = 0; p1_l = 0;
        end
        m_err = ld_valid && m_busy;
        if (!m_busy && ld_valid && ld_row < NCH && ld_col < NCH) begin
            c_re[ld_row][ld_col] = int'(ld_re);
            c_im[ld_row][ld_col] = int'(ld_im);
        end
        if (m_busy) begin
            if (m_s == m_k-1) begin
                m_s = 0;
                if (m_v == cnt-1) begin m_busy = 0; q_re.delete(); q_im.delete(); end
                else m_v++;
            end else m_s++;
        end else if (start && cnt > 0) begin
            m_busy = 1; m_v = 0; m_s = 0; m_ovf = 0;
            m_k = (k_active == 0) ? 1 : (k_active > NCH) ? NCH : int'(k_active);
        end else if (in_valid) begin
            if (cnt < DEPTH) begin
                for (int c = 0; c < NCH; c++) begin
                    q_re.push_back(int'($signed(in_re[c*SW +: SW])));
                    q_im.push_back(int'($signed(in_im[c*SW +: SW])));
                end
            end else m_ovf = 1;
        end
    endtask

    task automatic compare();
        chk("R6 out_valid", out_valid, o_v);
        if (o_v) begin
            chk("R5 out_re", out_re, o_re);
            chk("R5 out_im", out_im, o_im);
            chk("R6 out_slice", out_slice, o_s);
        end
        chk("R7 out_last", out_last, o_v && o_l);
        chk("R3 busy", busy, m_busy);
        chk("R1 full", full, (q_re.size()/NCH) == DEPTH);
        chk("R2 ovf", ovf, m_ovf);
        chk("R9 ld_err", ld_err, m_err);
        if (out_valid === 1'b1) begin beats++; last_re = out_re; last_im = out_im; end
    endtask

    task automatic tick();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic put_vec(input int seed);
        for (int c = 0; c < NCH; c++) begin
            in_re[c*SW +: SW] = 16'(sval(seed*13 + c));
            in_im[c*SW +: SW] = 16'(sval(seed*29 + c*5 + 7));
        end
        in_valid = 1; tick(); in_valid = 0;
    endtask

    task automatic load(input int r, input int c, input int vr, input int vi);
        ld_valid = 1; ld_row = 4'(r); ld_col = 4'(c); ld_re = 16'(vr); ld_im = 16'(vi);
        tick(); ld_valid = 0;
    endtask

    task automatic run(input int k);
        k_active = 4'(k); start = 1; beats = 0;
        tick(); start = 0;
        while (busy === 1'b1) tick();
        repeat (3) tick();
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        tick(); tick();
        rst_n = 1;
        tick();
        // R3 reset state: idle, nothing stored
        chk("R3 reset busy", busy, 0);
        chk("R1 reset full", full, 0);

        // R8: single coefficient, hand-computed result
        load(0, 3, 2, -1);
        load(12, 0, 99, 99);
        load(0, 15, 77, 77);
        for (int c = 0; c < NCH; c++) begin
            in_re[c*SW +: SW] = 16'(c*100 + 1);
            in_im[c*SW +: SW] = 16'(-c*50);
        end
        in_re[3*SW +: SW] = 16'(5); in_im[3*SW +: SW] = 16'(7);
        in_valid = 1; tick(); in_valid = 0;
        run(1);
        chk("R8 loaded coef re", last_re, 17);
        chk("R8 loaded coef im", last_im, 9);

        // full matrix with extreme values
        for (int r = 0; r < NCH; r++)
            for (int c = 0; c < NCH; c++)
                load(r, c, sval(r*12 + c + 500), sval(r*12 + c + 900));
        load(1, 1, -32768, -32768);

        // R9, R11: loads and input during a run
        for (int i = 0; i < 5; i++) put_vec(i + 40);
        k_active = 3; start = 1; beats = 0; tick(); start = 0;
        for (int i = 0; i < 4; i++) begin
            ld_valid = 1; ld_row = 0; ld_col = 0; ld_re = 16'(1234); ld_im = 16'(-4321);
            in_valid = 1; tick();
        end
        ld_valid = 0; in_valid = 0;
        while (busy === 1'b1) tick();
        repeat (3) tick();
        chk("R6 beat count 5x3", beats, 15);
        // R10: buffer empty, a bare start is ignored
        start = 1; tick(); start = 0;
        chk("R10 start on empty ignored", busy, 0);
        tick();
        put_vec(77);
        run(2);
        chk("R11 inputs during run not stored", beats, 2);

        // R4: clamping of the slice count
        put_vec(3); put_vec(4);
        run(0);
        chk("R4 k=0 runs as 1", beats, 2);
        put_vec(5); put_vec(6);
        run(15);
        chk("R4 k=15 runs as 12", beats, 24);
        put_vec(7); put_vec(8); put_vec(9);
        run(12);
        chk("R6 beat count 3x12", beats, 36);

        // R2, R1: fill past depth
        for (int i = 0; i < DEPTH + 3; i++) put_vec(i + 1000);
        chk("R1 full after depth", full, 1);
        chk("R2 ovf after extra input", ovf, 1);
        run(1);
        chk("R1 all stored vectors emitted", beats, DEPTH);
        chk("R2 ovf cleared by start", ovf, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule